// File: doc/BRIEF.md
# Page Translation Lookaside Buffer

This block keeps recently used virtual-to-physical page mappings so that most address translations avoid a page-table access. A requester presents a virtual page number on the lookup port. One cycle later the block returns a registered response: hit with the physical page number, or miss with a request to walk the page table. The page-table unit answers a walk by writing the mapping back through the fill port.

When the page table reclaims a physical frame, it sends the evicted virtual page number on the invalidate port, and any entry holding that page is dropped. A global enable input switches the block into bypass. In bypass every lookup is handed to the page table, the block reports neither hit nor miss, and fills are ignored.

Entries are organised as a set-associative array. The number of sets is a power of two from 2 to 256, and there are 1 to 8 ways per set. Each set uses least-recently-used replacement. Two saturating counters report the hits and misses seen while enabled.

Top module: `pgmap_tlb`

## Requirements
- R1: The set index is the low log2(SETS) bits of the virtual page number and the tag is the remaining upper bits. With 4 sets, page 0x00C maps to set 0 and page 0x00D maps to set 1, and an entry in one set never answers for a page of another set.
- R2: A lookup presented with `lk_valid` high at a clock edge produces `rsp_valid` high on the next cycle. When the lookup hits, `rsp_hit` is high and `rsp_ppn` holds the stored physical page. When `lk_valid` is low, `rsp_valid` is low on the next cycle.
- R3: `rsp_walk` is high for every lookup response that is not a hit and low for a hit, so the number of page-table requests equals the number of misses.
- R4: A fill writes into the lowest-numbered invalid way of its set when one exists, and evicts no valid entry in that case.
- R5: When every way of the set is valid, a fill replaces the least recently used way. Both a hit and a fill count as a use, and the recency update happens at the same edge that registers the hit result.
- R6: An invalidate removes the entry holding the given virtual page, so later lookups of that page miss. An invalidate of a page that is not held changes no other entry.
- R7: While `enable` is low, a lookup response has `rsp_valid` and `rsp_walk` high and both `rsp_hit` and `rsp_miss` low. Fills are ignored and neither counter moves.
- R8: `hit_count` and `miss_count` count enabled hits and misses. They are CNT_W bits wide (32 by default), saturate at all ones, and are zero after reset.
- R9: Synchronous active-high reset empties every entry and clears all response outputs.
- R10: A response never has hit and miss together. A fill of a page already held rewrites that entry in place, so at most one way ever matches a page. An invalidate and a fill of the same page in the same cycle leave the page absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Translation caching on; low selects bypass |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to look up |
| fill_valid | input | 1 | Fill request from the page-table unit |
| fill_vpn | input | VPN_W | Virtual page being filled |
| fill_ppn | input | PPN_W | Physical page for the fill |
| inv_valid | input | 1 | Invalidate request on page eviction |
| inv_vpn | input | VPN_W | Virtual page to invalidate |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss while enabled |
| rsp_walk | output | 1 | Page table must be consulted |
| rsp_ppn | output | PPN_W | Physical page on a hit, zero otherwise |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
The lookup path is driven with a sequence that first fills one set to capacity. It then reorders recency with hits, so the bench can tell true least-recently-used replacement from fixed-way or first-in replacement. An invalidate followed by a refill checks that the freed way is reused ahead of the LRU victim. Lookups across two sets that share upper tag bits separate correct index slicing from wrong slicing. A remap of a resident page, bypass traffic with an ignored fill, counter saturation and a mid-run reset each expose a distinct fault in the update paths.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int MAX_SETS = 256;
  localparam int MAX_WAYS = 8;

  function automatic int way_bits(input int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction
endpackage

// File: rtl/pgmap_satcnt.sv
module pgmap_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (inc && (q != {W{1'b1}})) q <= q + 1'b1;
  end

  // R8: once saturated the counter stays put
  a_r8_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (q == {W{1'b1}}) |=> (q == {W{1'b1}}));
  // R8: the counter only holds or steps by one
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q == $past(q)) || (q == $past(q) + W'(1))));
endmodule

// File: rtl/pgmap_lru.sv
module pgmap_lru #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int IDX_W = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WAY_W-1:0] victim
);
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

  logic [AGE_W-1:0] age [SETS][WAYS];
  logic [WAYS-1:0]  oldest_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age[touch_idx][w] <= '0;
        else if (age[touch_idx][w] < age[touch_idx][touch_way])
          age[touch_idx][w] <= age[touch_idx][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim     = '0;
    oldest_vec = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age[q_idx][w] == OLDEST) begin
        victim        = WAY_W'(w);
        oldest_vec[w] = 1'b1;
      end
    end
  end

  // R5: the ages of a set stay a permutation, so exactly one way is oldest
  a_r5_one_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/pgmap_ways.sv
module pgmap_ways #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int IDX_W = 2,
  parameter int TAG_W = 11,
  parameter int PPN_W = 10,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic [PPN_W-1:0] hit_ppn,
  input  logic [IDX_W-1:0] fi_idx,
  input  logic [TAG_W-1:0] fi_tag,
  output logic [WAYS-1:0]  fi_match,
  output logic [WAYS-1:0]  fi_valid,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag
);
  logic [WAYS-1:0]  vld   [SETS];
  logic [TAG_W-1:0] tag_m [SETS][WAYS];
  logic [PPN_W-1:0] ppn_m [SETS][WAYS];

  // payload storage carries no reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_m[fi_idx][wr_way] <= fi_tag;
      ppn_m[fi_idx][wr_way] <= wr_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else begin
      if (wr_en) vld[fi_idx][wr_way] <= 1'b1;
      if (inv_en)
        for (int w = 0; w < WAYS; w++)
          if (vld[inv_idx][w] && (tag_m[inv_idx][w] == inv_tag))
            vld[inv_idx][w] <= 1'b0;
    end
  end

  always_comb begin
    hit_ppn = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w]  = vld[lk_idx][w] && (tag_m[lk_idx][w] == lk_tag);
      fi_match[w] = vld[fi_idx][w] && (tag_m[fi_idx][w] == fi_tag);
      fi_valid[w] = vld[fi_idx][w];
      if (hit_vec[w]) hit_ppn = hit_ppn | ppn_m[lk_idx][w];
    end
  end

  // R10: a page is never held in two ways of its set
  a_r10_one_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/pgmap_tlb.sv
module pgmap_tlb #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int VPN_W = 13,
  parameter int PPN_W = 10,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_walk,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  import pgmap_pkg::*;

  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = way_bits(WAYS);

  initial begin
    a_cfg: assert (SETS >= 2 && SETS <= MAX_SETS && (SETS & (SETS - 1)) == 0
                   && WAYS >= 1 && WAYS <= MAX_WAYS && TAG_W >= 1);
  end

  logic [IDX_W-1:0] lk_idx, fi_idx, inv_idx;
  logic [TAG_W-1:0] lk_tag, fi_tag, inv_tag;
  assign lk_idx  = lk_vpn[IDX_W-1:0];
  assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
  assign fi_idx  = fill_vpn[IDX_W-1:0];
  assign fi_tag  = fill_vpn[VPN_W-1:IDX_W];
  assign inv_idx = inv_vpn[IDX_W-1:0];
  assign inv_tag = inv_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0]  hit_vec, fi_match, fi_valid;
  logic [PPN_W-1:0] hit_ppn;
  logic [WAY_W-1:0] victim, fill_way, hit_way;
  logic             look_act, look_hit, fill_act;

  assign look_act = lk_valid && enable;
  assign look_hit = look_act && (|hit_vec);
  assign fill_act = fill_valid && enable && !(inv_valid && (inv_vpn == fill_vpn));

  always_comb begin
    fill_way = victim;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!fi_valid[w]) fill_way = WAY_W'(w);
    for (int w = 0; w < WAYS; w++)
      if (fi_match[w]) fill_way = WAY_W'(w);
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  pgmap_ways #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .PPN_W(PPN_W), .WAY_W(WAY_W)
  ) u_ways (
    .clk(clk), .rst(rst),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .hit_vec(hit_vec), .hit_ppn(hit_ppn),
    .fi_idx(fi_idx), .fi_tag(fi_tag), .fi_match(fi_match), .fi_valid(fi_valid),
    .wr_en(fill_act), .wr_way(fill_way), .wr_ppn(fill_ppn),
    .inv_en(inv_valid), .inv_idx(inv_idx), .inv_tag(inv_tag)
  );

  pgmap_lru #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(fill_act || look_hit),
    .touch_idx(fill_act ? fi_idx : lk_idx),
    .touch_way(fill_act ? fill_way : hit_way),
    .q_idx(fi_idx), .victim(victim)
  );

  pgmap_satcnt #(.W(CNT_W)) u_hits (
    .clk(clk), .rst(rst), .inc(look_hit), .q(hit_count));
  pgmap_satcnt #(.W(CNT_W)) u_miss (
    .clk(clk), .rst(rst), .inc(look_act && !look_hit), .q(miss_count));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_walk  <= 1'b0;
      rsp_ppn   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= look_hit;
      rsp_miss  <= look_act && !look_hit;
      rsp_walk  <= lk_valid && !look_hit;
      rsp_ppn   <= look_hit ? hit_ppn : '0;
    end
  end

  // R10: hit and miss are exclusive
  a_r10_excl: assert property (@(posedge clk) disable iff (rst)
    !(rsp_hit && rsp_miss));
  // R3: a walk is requested exactly for valid responses that did not hit
  a_r3_walk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_walk == !rsp_hit));
  // R7: bypass lookups report neither outcome and go to the page table
  a_r7_bypass: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !enable) |=> (rsp_valid && rsp_walk && !rsp_hit && !rsp_miss));
  // R2: no response without a lookup
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
endmodule

// File: tb/pgmap_tlb_bench.sv
`timescale 1ns/1ps
module pgmap_tlb_bench;
  localparam int VPN_W = 13;
  localparam int PPN_W = 10;
  localparam int CNT_W = 4;
  localparam logic [1:0] OL = 2'd0, OF = 2'd1, OI = 2'd2;

  typedef struct packed {
    logic [1:0]       op;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             hit;
    logic [PPN_W-1:0] eppn;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{OL, 13'h00C, 10'h0, 1'b0, 10'h0},   // R2 R3 cold miss
    '{OF, 13'h00C, 10'h5, 1'b0, 10'h0},
    '{OL, 13'h00C, 10'h0, 1'b1, 10'h5},   // R2 hit
    '{OF, 13'h010, 10'h7, 1'b0, 10'h0},   // R4 into free way
    '{OL, 13'h010, 10'h0, 1'b1, 10'h7},
    '{OL, 13'h00C, 10'h0, 1'b1, 10'h5},   // R5 recency update
    '{OF, 13'h020, 10'h9, 1'b0, 10'h0},   // R5 evicts 0x010
    '{OL, 13'h010, 10'h0, 1'b0, 10'h0},
    '{OL, 13'h00C, 10'h0, 1'b1, 10'h5},
    '{OL, 13'h020, 10'h0, 1'b1, 10'h9},
    '{OI, 13'h020, 10'h0, 1'b0, 10'h0},   // R6
    '{OL, 13'h020, 10'h0, 1'b0, 10'h0},
    '{OF, 13'h030, 10'hA, 1'b0, 10'h0},   // R4 reuses freed way
    '{OL, 13'h00C, 10'h0, 1'b1, 10'h5},
    '{OL, 13'h030, 10'h0, 1'b1, 10'hA},
    '{OL, 13'h00D, 10'h0, 1'b0, 10'h0},   // R1 other set
    '{OI, 13'h00D, 10'h0, 1'b0, 10'h0},   // R6 absent page
    '{OL, 13'h00C, 10'h0, 1'b1, 10'h5},
    '{OL, 13'h030, 10'h0, 1'b1, 10'hA},
    '{OF, 13'h00C, 10'h11, 1'b0, 10'h0},  // R10 remap in place
    '{OL, 13'h00C, 10'h0, 1'b1, 10'h11},
    '{OL, 13'h030, 10'h0, 1'b1, 10'hA},
    '{OF, 13'h00D, 10'h3, 1'b0, 10'h0},   // R1 set 1 fill
    '{OL, 13'h00D, 10'h0, 1'b1, 10'h3},
    '{OL, 13'h030, 10'h0, 1'b1, 10'hA},
    '{OL, 13'h00C, 10'h0, 1'b1, 10'h11}
  };

  logic clk = 1'b0, rst = 1'b1, enable = 1'b1;
  logic lk_valid = 1'b0, fill_valid = 1'b0, inv_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0, rsp_ppn;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_walk;
  logic [CNT_W-1:0] hit_count, miss_count;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pgmap_tlb #(.SETS(4), .WAYS(2), .VPN_W(VPN_W), .PPN_W(PPN_W), .CNT_W(CNT_W)) u_pgmap_tlb (
    .clk(clk), .rst(rst), .enable(enable),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_walk(rsp_walk), .rsp_ppn(rsp_ppn),
    .hit_count(hit_count), .miss_count(miss_count));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one operation: drive at a falling edge, sample at the next falling edge
  task automatic do_op(input logic [1:0] op, input logic [VPN_W-1:0] vpn,
                       input logic [PPN_W-1:0] ppn);
    @(negedge clk);
    lk_valid   = (op == OL); lk_vpn   = vpn;
    fill_valid = (op == OF); fill_vpn = vpn; fill_ppn = ppn;
    inv_valid  = (op == OI); inv_vpn  = vpn;
    @(negedge clk);
    lk_valid = 1'b0; fill_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic look_chk(input string req, input logic [VPN_W-1:0] vpn,
                          input logic hit, input logic [PPN_W-1:0] ppn);
    do_op(OL, vpn, '0);
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " hit"},  32'(rsp_hit),  32'(hit));
    check({req, " miss"}, 32'(rsp_miss), 32'(!hit));
    check({req, " walk R3"}, 32'(rsp_walk), 32'(!hit));
    check({req, " ppn"},  32'(rsp_ppn),  32'(hit ? ppn : '0));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 R8 reset state
    check("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R9 rsp_walk",  32'(rsp_walk),  32'd0);
    check("R8 hit_count reset",  32'(hit_count),  32'd0);
    check("R8 miss_count reset", 32'(miss_count), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == OL) begin
        look_chk($sformatf("R2 vec%0d", i), VEC[i].vpn, VEC[i].hit, VEC[i].eppn);
      end else begin
        do_op(VEC[i].op, VEC[i].vpn, VEC[i].ppn);
        check($sformatf("R2 idle vec%0d", i), 32'(rsp_valid), 32'd0);
      end
    end
    check("R8 hits after table",   32'(hit_count),  32'd14);
    check("R8 misses after table", 32'(miss_count), 32'd4);

    // R7 bypass: no outcome, walk requested, counters frozen, fill ignored
    enable = 1'b0;
    do_op(OL, 13'h00C, '0);
    check("R7 valid", 32'(rsp_valid), 32'd1);
    check("R7 hit",   32'(rsp_hit),   32'd0);
    check("R7 miss",  32'(rsp_miss),  32'd0);
    check("R7 walk",  32'(rsp_walk),  32'd1);
    do_op(OF, 13'h040, 10'h1);
    check("R7 hits frozen",   32'(hit_count),  32'd14);
    check("R7 misses frozen", 32'(miss_count), 32'd4);
    enable = 1'b1;
    look_chk("R7 fill ignored", 13'h040, 1'b0, '0);
    check("R8 miss count", 32'(miss_count), 32'd5);

    // R10 same-cycle invalidate and fill of one page leaves it absent
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = 13'h050; fill_ppn = 10'h2;
    inv_valid  = 1'b1; inv_vpn  = 13'h050;
    @(negedge clk);
    fill_valid = 1'b0; inv_valid = 1'b0;
    look_chk("R10 inv beats fill", 13'h050, 1'b0, '0);

    // R8 saturation at all ones
    look_chk("R8 sat a", 13'h00C, 1'b1, 10'h11);
    check("R8 count 15", 32'(hit_count), 32'd15);
    look_chk("R8 sat b", 13'h00C, 1'b1, 10'h11);
    check("R8 saturated", 32'(hit_count), 32'd15);

    // R9 reset empties the array and counters
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R9 hits cleared", 32'(hit_count), 32'd0);
    look_chk("R9 entry gone", 13'h00C, 1'b0, '0);
    check("R9 miss after reset", 32'(miss_count), 32'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule